// File: doc/BRIEF.md
# Credit-Gated Ready/Valid Pass-Through

This block sits in a ready/valid stream and lets an item cross only while it holds at least one credit. Credits are stored in an internal saturating counter. A single-bit credit input adds one credit on every clock cycle in which it is high. Every item that crosses, meaning a cycle in which the upstream side offers valid data and the downstream side is ready, removes one credit.

The data word and both handshake signals are wired straight through in the same cycle, with no register in the data path. When the counter reads zero, the block holds both the downstream valid and the upstream ready low, so neither side sees a completed transfer. A typical use is to release exactly as many items as some other agent has granted. An operation can then be treated as finished once that number of items has left.

The current credit count is an output. A synchronous reset clears the count to zero.

Top module: `credit_gate`

## Requirements
- R1: After a synchronous reset the credit count is 0, and `out_valid` and `in_ready` are both low, whatever `in_valid` and `out_ready` are.
- R2: While the credit count is 0, `out_valid` and `in_ready` stay low, so no transfer completes and the count cannot go below 0.
- R3: A cycle with `credit_in` high and no transfer raises the count by exactly 1 at the next clock edge.
- R4: When `credit_in` is held high for N consecutive cycles with no transfers, the count rises by N, provided it stays below the maximum.
- R5: A transfer happens in a cycle with `in_valid`, `out_ready` and a non-zero count. A transfer without `credit_in` lowers the count by exactly 1 at the next clock edge.
- R6: A cycle with both a transfer and `credit_in` high leaves the count unchanged.
- R7: While the count is non-zero, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data`, all in the same cycle.
- R8: The count saturates at 2^CNT_W-1. At that value, a credit with no transfer leaves the count unchanged and does not wrap to 0.
- R9: `out_data` always equals `in_data`, whatever the credit count is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| credit_in | input | 1 | Adds one credit for each cycle it is high |
| in_valid | input | 1 | Upstream valid |
| in_ready | output | 1 | Upstream ready, gated by credit availability |
| in_data | input | DATA_W | Upstream data |
| out_valid | output | 1 | Downstream valid, gated by credit availability |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Downstream data, equal to `in_data` |
| credit_count | output | CNT_W | Current number of stored credits |

## Verification
The assertions check on every cycle that the handshake is blocked at zero credits and passed through otherwise. They also check each counter step: plus one, minus one, no change on a simultaneous credit and transfer, and the hold at the ceiling. Only the bench scenarios can show the accumulated effects. These are a long held credit input adding exactly its length, draining the count to zero and then being refused, and the count reaching saturation and staying there. A long random mix of credits and back-pressure, compared against an independent model, shows that the count never drifts over thousands of cycles.

// File: rtl/cg_pkg.sv
package cg_pkg;

  // Next credit value for a counter whose ceiling is 'limit'.
  // Adding and taking in the same cycle cancel each other out.
  function automatic logic [31:0] next_credit(input logic [31:0] cur,
                                              input logic        add,
                                              input logic        take,
                                              input logic [31:0] limit);
    logic [31:0] res;
    res = cur;
    if (add && !take) begin
      if (cur != limit) res = cur + 32'd1;
    end else if (take && !add) begin
      if (cur != 32'd0) res = cur - 32'd1;
    end
    return res;
  endfunction

  // A transfer completes only when both sides agree and a credit exists.
  function automatic logic transfer_fires(input logic valid,
                                          input logic ready,
                                          input logic have_credit);
    return valid & ready & have_credit;
  endfunction

endpackage

// File: rtl/cg_credit_counter.sv
module cg_credit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] count_o,
  output logic             nonzero_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LIMIT = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_next;

  always_comb begin
    cnt_next = cg_pkg::next_credit(32'(cnt_q), add_i, take_i, 32'(LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next[CNT_W-1:0];
  end

  assign count_o   = cnt_q;
  assign nonzero_o = (cnt_q != '0);
  assign full_o    = (cnt_q == LIMIT);
endmodule

// File: rtl/cg_handshake_gate.sv
module cg_handshake_gate #(
  parameter int DATA_W = 16
) (
  input  logic              enable_i,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              fire_o
);
  always_comb begin
    dn_valid_o = up_valid_i & enable_i;
    up_ready_o = dn_ready_i & enable_i;
    dn_data_o  = up_data_i;
    fire_o     = cg_pkg::transfer_fires(up_valid_i, dn_ready_i, enable_i);
  end
endmodule

// File: rtl/credit_gate.sv
module credit_gate #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              credit_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  credit_count
);
  // Named internal events, brought out for the checker.
  logic credit_avail;
  logic credit_full;
  logic xfer_fire;
  logic credit_add;

  assign credit_add = credit_in;

  cg_handshake_gate #(.DATA_W(DATA_W)) gate_i (
    .enable_i   (credit_avail),
    .up_valid_i (in_valid),
    .up_ready_o (in_ready),
    .up_data_i  (in_data),
    .dn_valid_o (out_valid),
    .dn_ready_i (out_ready),
    .dn_data_o  (out_data),
    .fire_o     (xfer_fire)
  );

  cg_credit_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .add_i     (credit_add),
    .take_i    (xfer_fire),
    .count_o   (credit_count),
    .nonzero_o (credit_avail),
    .full_o    (credit_full)
  );
endmodule

// File: rtl/credit_gate_chk.sv
module credit_gate_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              credit_in,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  credit_count,
  input logic              xfer_fire
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (credit_count == '0 && !out_valid && !in_ready)); // R1
  AST_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (rst) (credit_count == '0) |-> (!out_valid && !in_ready)); // R2
  AST_ADD_ONE: assert property (@(posedge clk) disable iff (rst) (credit_in && !(in_valid && out_ready && credit_count != '0) && credit_count != TOP) |=> (credit_count == CNT_W'($past(credit_count) + 1'b1))); // R3
  AST_TAKE_ONE: assert property (@(posedge clk) disable iff (rst) (!credit_in && in_valid && out_ready && credit_count != '0) |=> (credit_count == CNT_W'($past(credit_count) - 1'b1))); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst) (credit_in && in_valid && out_ready && credit_count != '0) |=> $stable(credit_count)); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst) (credit_count != '0) |-> (out_valid == in_valid && in_ready == out_ready)); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (credit_count == TOP && !xfer_fire) |=> (credit_count == TOP)); // R8
  AST_DATA_EQ: assert property (@(posedge clk) disable iff (rst) out_data == in_data); // R9
endmodule

bind credit_gate credit_gate_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .credit_in    (credit_in),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .credit_count (credit_count),
  .xfer_fire    (xfer_fire)
);

// File: tb/credit_gate_tb_top.sv
`timescale 1ns/1ps
module credit_gate_tb_top;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              credit_in = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic [CNT_W-1:0]  credit_count;

  int applied = 0;
  int bad     = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  credit_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .credit_in(credit_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .credit_count(credit_count)
  );

  // Independent restatement of the counter rules.
  function automatic int model_next(int cur, bit cr, bit moved);
    int delta;
    delta = (cr ? 1 : 0) - (moved ? 1 : 0);
    if (cur + delta > MAXC) return MAXC;
    if (cur + delta < 0) return 0;
    return cur + delta;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check outputs, advance the model.
  task automatic step(bit cr, bit iv, bit ordy, logic [DATA_W-1:0] d, string tag);
    bit moved;
    @(negedge clk);
    credit_in = cr; in_valid = iv; out_ready = ordy; in_data = d;
    #1;
    check(int'(credit_count) == model, {tag, " count"}, int'(credit_count), model);
    check(out_valid == (iv && model != 0), {tag, " out_valid (R2/R7)"}, int'(out_valid), int'(iv && model != 0));
    check(in_ready == (ordy && model != 0), {tag, " in_ready (R2/R7)"}, int'(in_ready), int'(ordy && model != 0));
    check(out_data == d, {tag, " data (R9)"}, int'(out_data), int'(d));
    moved = iv && ordy && (model != 0);
    model = model_next(model, cr, moved);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      applied++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250623));
    rst = 1'b1;
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b1; credit_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    credit_in = 1'b0;
    #1;
    // R1: reset state, with both handshake inputs held high
    check(credit_count == '0, "R1 count", int'(credit_count), 0);
    check(!out_valid && !in_ready, "R1 handshake low", int'(out_valid | in_ready), 0);
    model = 0;

    // R2: zero credits block transfers, and the count stays at zero
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 16'h1111, "R2 blocked");
    // R3: single credit pulses
    step(1'b1, 1'b0, 1'b0, 16'h0, "R3 pulse");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R3 gap");
    step(1'b1, 1'b0, 1'b1, 16'h0, "R3 pulse");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R3 after");
    check(model == 2, "R3 model", model, 2);
    // R4: held credit input for 10 cycles
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 16'h0, "R4 held");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R4 after");
    // R6: credit and transfer in the same cycle
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 16'hA5A5, "R6 both");
    // R5: drain to zero, then try to go further
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b1, 16'(i), "R5 drain");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R5 at zero");
    // R8: saturate at the ceiling
    for (int i = 0; i < MAXC + 8; i++) step(1'b1, 1'b0, 1'b0, 16'h0, "R8 fill");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R8 ceiling");
    step(1'b1, 1'b1, 1'b1, 16'h5A5A, "R8 both at top");
    step(1'b0, 1'b1, 1'b1, 16'h0F0F, "R8 take at top");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R8 after");
    // Random mix (R3, R5, R6, R7)
    for (int i = 0; i < 3000; i++) begin
      bit cr;
      bit iv;
      bit ordy;
      cr = ($urandom % 3) == 0;
      iv = ($urandom % 4) != 0;
      ordy = ($urandom % 3) != 0;
      step(cr, iv, ordy, 16'($urandom), "R7 random");
    end
    // Back-pressure with credits: no transfer, no consumption (R5)
    step(1'b0, 1'b1, 1'b0, 16'h7777, "R5 stalled");
    step(1'b0, 1'b0, 1'b0, 16'h0, "R5 stalled after");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule